// File: doc/BRIEF.md
# Byte/Word Load-Store Lane Unit

This block sits between a 16-bit processor core and a byte-addressable memory whose data bus is one 16-bit word wide and has a write/read enable per byte. The core hands it one request at a time. A request carries a base register value, a 4-bit signed displacement, a direction bit (load or store), a 3-bit operation code and the store data. The unit adds the displacement to the base to form the byte address. It then presents the memory with the even word address, the byte-lane enables and lane-steered write data. On loads it extends the returned byte or word to 16 bits.

Memory is little-endian: the byte at the even address travels on lane 0 (bits 7:0) and the byte at the odd address travels on lane 1 (bits 15:8). Word accesses must fall on an even address. An odd word address produces a one-cycle misalignment pulse instead of a memory access. Accesses whose byte address lies in the I/O window at the top of the address space raise an extra select output beside the normal strobe. The memory is synchronous, so load data returns one cycle after the request is accepted and carries a response-valid strobe.

Top module: `ls_lane_unit`

## Requirements
- R1: The byte address is the base plus the sign-extended 4-bit displacement (range -8 to +7), taken modulo 2^16. mem_addr carries that address with bit 0 cleared.
- R2: A store with op code 000 writes one byte. mem_be is 01 for an even address and 10 for an odd address. The low byte of the store data appears on the enabled lane, and the other byte in memory is left unchanged.
- R3: A store with op code 001 at an even address drives mem_be = 11 and mem_wdata equal to the store data, with the low byte on bits 7:0.
- R4: A load with op code 000 returns the addressed byte sign-extended to 16 bits. The byte is taken from bits 7:0 of mem_rdata for an even address and from bits 15:8 for an odd address.
- R5: A load with op code 100 returns the addressed byte zero-extended to 16 bits.
- R6: A load with op code 001 at an even address returns the full 16-bit word.
- R7: mem_we or mem_re is asserted combinationally in the cycle the request is accepted (req_valid and req_ready both high). For a load, rsp_valid is high for exactly the following cycle, with rsp_data valid. Stores produce no rsp_valid.
- R8: A word access (op code 001) at an odd address drives neither mem_we nor mem_re. It raises fault_misalign for the one following cycle and gives no rsp_valid. Memory contents are unchanged.
- R9: io_select is high together with the strobe exactly when the byte address is in 0xF000 to 0xFFFF.
- R10: A store op code other than 000 or 001, or a load op code other than 000, 001 or 100, drives no strobe. It raises no fault and no rsp_valid.
- R11: While rst_n is low, req_ready, mem_we, mem_re, rsp_valid and fault_misalign are low. req_ready rises on the first clock edge after reset is released.
- R12: Byte accesses at odd addresses are carried out normally and never raise fault_misalign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_op | input | 3 | Operation code: size and extension |
| req_base | input | 16 | Base register value |
| req_disp | input | 4 | Signed displacement |
| req_wdata | input | 16 | Store data |
| mem_addr | output | 16 | Even word address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_be | output | 2 | Byte-lane enables, bit 0 = even byte |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| io_select | output | 1 | Access targets the I/O window |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 16 | Extended load result |
| fault_misalign | output | 1 | Odd-address word access pulse |

## Verification
The bench builds the unit with its default parameters: a 16-bit address and data path, a 4-bit displacement and the I/O window starting at 0xF000. With those values the window spans exactly the top 4 KB, so the mask-compare variant of the window decode is the one exercised. A base of 0xEFFF plus one lands on the first I/O byte, a base of 0xFFFE plus seven wraps to the bottom of memory, and the most negative displacement of -8 is reachable. Lane selection and all three extension modes are compared against a byte-array memory model in the bench.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   // direction-dependent operation codes
   localparam logic [2:0] OP_ST_BYTE  = 3'b000;
   localparam logic [2:0] OP_ST_WORD  = 3'b001;
   localparam logic [2:0] OP_LD_SBYTE = 3'b000;
   localparam logic [2:0] OP_LD_WORD  = 3'b001;
   localparam logic [2:0] OP_LD_UBYTE = 3'b100;

   typedef enum logic [1:0] {
      EXT_WORD  = 2'd0,
      EXT_SBYTE = 2'd1,
      EXT_UBYTE = 2'd2
   } ext_mode_t;

   typedef struct packed {
      logic      is_load;
      logic      is_store;
      logic      is_word;
      ext_mode_t ext;
   } op_dec_t;

   function automatic op_dec_t decode_op(input logic st, input logic [2:0] op);
      op_dec_t d;
      d = '0;
      if (st) begin
         case (op)
            OP_ST_BYTE: d.is_store = 1'b1;
            OP_ST_WORD: begin
               d.is_store = 1'b1;
               d.is_word  = 1'b1;
            end
            default: ;
         endcase
      end else begin
         case (op)
            OP_LD_SBYTE: begin
               d.is_load = 1'b1;
               d.ext     = EXT_SBYTE;
            end
            OP_LD_WORD: begin
               d.is_load = 1'b1;
               d.is_word = 1'b1;
               d.ext     = EXT_WORD;
            end
            OP_LD_UBYTE: begin
               d.is_load = 1'b1;
               d.ext     = EXT_UBYTE;
            end
            default: ;
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
   parameter int          ADDR_W  = 16,
   parameter int          DISP_W  = 4,
   parameter int          LANES   = 2,
   parameter int unsigned IO_BASE = 32'h0000_F000
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [ADDR_W-1:0] word_addr,
   output logic [$clog2(LANES)-1:0] lane,
   output logic              io_hit
);
   localparam int          LANE_W  = $clog2(LANES);
   localparam longint      SPACE   = longint'(1) << ADDR_W;
   localparam longint      IO_SPAN = SPACE - longint'(IO_BASE);
   localparam bit          IO_POW2 = (IO_SPAN > 0) && ((IO_SPAN & (IO_SPAN - 1)) == 0);
   localparam int          IO_LOG  = IO_POW2 ? $clog2(IO_SPAN) : 0;
   localparam logic [ADDR_W-1:0] IO_BASE_V = IO_BASE[ADDR_W-1:0];

   if (DISP_W < 2 || DISP_W >= ADDR_W) begin : g_bad_disp
      $error("lsu_agen: DISP_W must be between 2 and ADDR_W-1");
   end
   if (ADDR_W > 30) begin : g_bad_addr
      $error("lsu_agen: ADDR_W too large");
   end
   if (IO_BASE == 0 || longint'(IO_BASE) >= SPACE) begin : g_bad_io
      $error("lsu_agen: IO_BASE must lie inside the address space and above zero");
   end

   logic [ADDR_W-1:0] disp_ext;
   assign disp_ext  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
   assign byte_addr = base + disp_ext;
   assign lane      = byte_addr[LANE_W-1:0];
   assign word_addr = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

   // window decode: a top-aligned power-of-two window needs only an AND of
   // the upper bits; any other base uses a magnitude compare
   if (IO_POW2 && IO_LOG < ADDR_W) begin : g_io_mask
      assign io_hit = &byte_addr[ADDR_W-1:IO_LOG];
   end else begin : g_io_cmp
      assign io_hit = (byte_addr >= IO_BASE_V);
   end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / 8
) (
   input  logic                     is_word,
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic [DATA_W-1:0]        wdata,
   output logic [LANES-1:0]         be,
   output logic [DATA_W-1:0]        bus_wdata
);
   if (LANES * 8 != DATA_W || LANES < 2) begin : g_bad_lanes
      $error("lsu_store_lanes: DATA_W must be a multiple of 8 with at least two lanes");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // a byte store copies the low byte onto every lane; only the enabled
      // lane is written by memory
      assign be[i]              = is_word | (lane == i);
      assign bus_wdata[i*8 +: 8] = is_word ? wdata[i*8 +: 8] : wdata[7:0];
   end

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
   import lsu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / 8
) (
   input  ext_mode_t                ext,
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic [DATA_W-1:0]        rdata,
   output logic [DATA_W-1:0]        result
);
   logic [7:0] picked;
   assign picked = rdata[lane*8 +: 8];

   always_comb begin
      case (ext)
         EXT_SBYTE: result = {{(DATA_W-8){picked[7]}}, picked};
         EXT_UBYTE: result = {{(DATA_W-8){1'b0}}, picked};
         default:   result = rdata;
      endcase
   end

endmodule

// File: rtl/ls_lane_unit.sv
module ls_lane_unit
   import lsu_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int          DATA_W  = 16,
   parameter int          DISP_W  = 4,
   parameter int unsigned IO_BASE = 32'h0000_F000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              io_select,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              fault_misalign
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   if (DATA_W != 16) begin : g_bad_data
      $error("ls_lane_unit: the lane layout is defined for a 16-bit bus");
   end

   op_dec_t           dec;
   logic [ADDR_W-1:0] byte_addr;
   logic [ADDR_W-1:0] word_addr;
   logic [LANE_W-1:0] lane;
   logic              io_hit;
   logic [LANES-1:0]  be_raw;
   logic [DATA_W-1:0] steer_wdata;
   logic [DATA_W-1:0] ext_result;
   logic              accept, legal, misalign, go;

   logic              ready_q;
   logic              rsp_q;
   logic              fault_q;
   logic [LANE_W-1:0] lane_q;
   ext_mode_t         ext_q;

   assign dec = decode_op(req_store, req_op);

   lsu_agen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .LANES  (LANES),
      .IO_BASE(IO_BASE)
   ) u_agen (
      .base     (req_base),
      .disp     (req_disp),
      .byte_addr(byte_addr),
      .word_addr(word_addr),
      .lane     (lane),
      .io_hit   (io_hit)
   );

   lsu_store_lanes #(
      .DATA_W(DATA_W),
      .LANES (LANES)
   ) u_steer (
      .is_word  (dec.is_word),
      .lane     (lane),
      .wdata    (req_wdata),
      .be       (be_raw),
      .bus_wdata(steer_wdata)
   );

   lsu_load_ext #(
      .DATA_W(DATA_W),
      .LANES (LANES)
   ) u_ext (
      .ext   (ext_q),
      .lane  (lane_q),
      .rdata (mem_rdata),
      .result(ext_result)
   );

   assign accept   = req_valid & req_ready;
   assign legal    = dec.is_load | dec.is_store;
   assign misalign = dec.is_word & (lane != '0);
   assign go       = accept & legal & ~misalign;

   assign req_ready = ready_q;
   assign mem_addr  = word_addr;
   assign mem_we    = go & dec.is_store;
   assign mem_re    = go & dec.is_load;
   assign mem_be    = go ? be_raw : '0;
   assign mem_wdata = steer_wdata;
   assign io_select = go & io_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         rsp_q   <= 1'b0;
         fault_q <= 1'b0;
         lane_q  <= '0;
         ext_q   <= EXT_WORD;
      end else begin
         ready_q <= 1'b1;
         rsp_q   <= mem_re;
         fault_q <= accept & legal & misalign;
         if (mem_re) begin
            lane_q <= lane;
            ext_q  <= dec.ext;
         end
      end
   end

   assign rsp_valid      = rsp_q;
   assign rsp_data       = rsp_q ? ext_result : '0;
   assign fault_misalign = fault_q;

   // R8: a fault pulse follows an accepted request that reached no memory
   a_r8_fault_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      fault_misalign |-> $past(req_valid && !mem_we && !mem_re));

   // R7: a response always follows a read strobe
   a_r7_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(mem_re));

   // R8: fault and response never coincide
   a_r8_fault_excludes_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_misalign && rsp_valid));

   // R9: the I/O select only accompanies a strobe
   a_r9_io_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      io_select |-> (mem_we || mem_re));

   // R2: every strobe enables at least one lane, a byte access exactly one
   a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_we || mem_re) && !dec.is_word) |-> ($countones(mem_be) == 1));

   // R3: word strobes always enable both lanes
   a_r3_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_we || mem_re) && dec.is_word) |-> (&mem_be));

   // R7: read and write strobes are exclusive
   a_r7_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R11: ready stays high once out of reset
   a_r11_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_ready) |-> req_ready);

endmodule

// File: tb/ls_lane_unit_test.sv
`timescale 1ns/100ps
module ls_lane_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_store;
   logic [2:0]  req_op;
   logic [15:0] req_base, req_wdata;
   logic [3:0]  req_disp;
   logic        req_ready;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, rsp_data;
   logic        mem_we, mem_re, io_select, rsp_valid, fault_misalign;
   logic [1:0]  mem_be;

   int checks = 0;
   int fails  = 0;

   // captured per request
   logic        c_we, c_re, c_io, r_valid, r_fault;
   logic [1:0]  c_be;
   logic [15:0] c_addr, c_wdata, r_data;

   logic [7:0] mem [256];

   always #2.5 clk = ~clk;

   ls_lane_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_op(req_op), .req_base(req_base),
      .req_disp(req_disp), .req_wdata(req_wdata), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .io_select(io_select), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .fault_misalign(fault_misalign)
   );

   // byte-array memory model, synchronous read
   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_be[0]) mem[{mem_addr[7:1], 1'b0}] <= mem_wdata[7:0];
         if (mem_be[1]) mem[{mem_addr[7:1], 1'b1}] <= mem_wdata[15:8];
      end
      if (mem_re)
         mem_rdata <= {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};
   end

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic issue(input logic st, input logic [2:0] op, input logic [15:0] base,
                        input logic [3:0] disp, input logic [15:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_op = op;
      req_base = base; req_disp = disp; req_wdata = data;
      #1;
      c_we = mem_we; c_re = mem_re; c_io = io_select;
      c_be = mem_be; c_addr = mem_addr; c_wdata = mem_wdata;
      @(posedge clk);
      #1;
      r_valid = rsp_valid; r_fault = fault_misalign; r_data = rsp_data;
      req_valid = 1'b0;
   endtask

   task automatic load_expect(input string tag, input logic [2:0] op, input logic [15:0] base,
                              input logic [3:0] disp, input logic [15:0] exp);
      issue(1'b0, op, base, disp, 16'h0000);
      check({tag, " read strobe"}, {15'd0, c_re}, 16'd1);
      check({tag, " rsp_valid"}, {15'd0, r_valid}, 16'd1);
      check({tag, " data"}, r_data, exp);
      check({tag, " no fault"}, {15'd0, r_fault}, 16'd0);
   endtask

   task automatic t_reset;
      check("R11 ready in reset", {15'd0, req_ready}, 16'd0);
      check("R11 strobes in reset", {14'd0, mem_we, mem_re}, 16'd0);
      check("R11 rsp/fault in reset", {14'd0, rsp_valid, fault_misalign}, 16'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R11 ready after reset", {15'd0, req_ready}, 16'd1);
   endtask

   task automatic t_stores;
      // R2 even byte store
      issue(1'b1, 3'b000, 16'h0010, 4'h0, 16'hA55A);
      check("R2 even be", {14'd0, c_be}, 16'h0001);
      check("R2 even lane data", {8'd0, c_wdata[7:0]}, 16'h005A);
      check("R1 addr even", c_addr, 16'h0010);
      check("R7 store no rsp", {15'd0, r_valid}, 16'd0);
      // R12 odd byte store, no fault
      issue(1'b1, 3'b000, 16'h0010, 4'h3, 16'h12C3);
      check("R2 odd be", {14'd0, c_be}, 16'h0002);
      check("R2 odd lane data", {8'd0, c_wdata[15:8]}, 16'h00C3);
      check("R1 addr odd cleared", c_addr, 16'h0012);
      check("R12 odd byte no fault", {15'd0, r_fault}, 16'd0);
      // R3 word store, displacement -8
      issue(1'b1, 3'b001, 16'h0020, 4'h8, 16'h80F7);
      check("R3 word be", {14'd0, c_be}, 16'h0003);
      check("R3 word data", c_wdata, 16'h80F7);
      check("R1 disp -8", c_addr, 16'h0018);
      check("R7 write strobe", {14'd0, c_we, c_re}, 16'h0002);
   endtask

   task automatic t_loads;
      load_expect("R4 sbyte even", 3'b000, 16'h0018, 4'h0, 16'hFFF7);
      load_expect("R4 sbyte odd",  3'b000, 16'h0018, 4'h1, 16'hFF80);
      load_expect("R5 ubyte odd",  3'b100, 16'h0018, 4'h1, 16'h0080);
      load_expect("R5 ubyte even", 3'b100, 16'h0010, 4'h0, 16'h005A);
      load_expect("R6 word",       3'b001, 16'h001A, 4'hE, 16'h80F7);
      load_expect("R12 sbyte odd lane", 3'b000, 16'h0014, 4'hF, 16'hFFC3);
      load_expect("R2 neighbour untouched", 3'b100, 16'h0011, 4'h0, 16'h0000);
      load_expect("R2 odd-store neighbour", 3'b100, 16'h0012, 4'h0, 16'h0000);
   endtask

   task automatic t_misalign;
      issue(1'b0, 3'b001, 16'h0019, 4'h0, 16'h0000);
      check("R8 load no strobe", {14'd0, c_we, c_re}, 16'd0);
      check("R8 load fault pulse", {15'd0, r_fault}, 16'd1);
      check("R8 load no rsp", {15'd0, r_valid}, 16'd0);
      @(posedge clk); #1;
      check("R8 fault one cycle", {15'd0, fault_misalign}, 16'd0);
      issue(1'b1, 3'b001, 16'h0017, 4'h0, 16'h1234);
      check("R8 store no strobe", {14'd0, c_we, c_re}, 16'd0);
      check("R8 store fault pulse", {15'd0, r_fault}, 16'd1);
      load_expect("R8 memory unchanged", 3'b001, 16'h0018, 4'h0, 16'h80F7);
      load_expect("R8 memory unchanged low", 3'b001, 16'h0016, 4'h0, 16'h0000);
   endtask

   task automatic t_io;
      issue(1'b1, 3'b000, 16'hEFFF, 4'h1, 16'h0077);
      check("R9 first io byte", {15'd0, c_io}, 16'd1);
      check("R9 io strobe", {15'd0, c_we}, 16'd1);
      check("R1 io addr", c_addr, 16'hF000);
      issue(1'b1, 3'b000, 16'hEFF0, 4'h7, 16'h0011);
      check("R9 below window", {15'd0, c_io}, 16'd0);
      issue(1'b1, 3'b000, 16'hFFFE, 4'h7, 16'h0022);
      check("R1 wrap addr", c_addr, 16'h0004);
      check("R1 wrap lane", {14'd0, c_be}, 16'h0002);
      check("R9 wrap not io", {15'd0, c_io}, 16'd0);
      issue(1'b0, 3'b100, 16'hFFFF, 4'h0, 16'h0000);
      check("R9 top byte io", {15'd0, c_io}, 16'd1);
      check("R9 top load rsp", {15'd0, r_valid}, 16'd1);
      issue(1'b0, 3'b001, 16'hF003, 4'hF, 16'h0000);
      check("R9 io word load", {14'd0, c_io, c_re}, 16'h0003);
   endtask

   task automatic t_illegal;
      issue(1'b0, 3'b010, 16'h0018, 4'h0, 16'h0000);
      check("R10 bad load strobes", {14'd0, c_we, c_re}, 16'd0);
      check("R10 bad load no rsp/fault", {14'd0, r_valid, r_fault}, 16'd0);
      issue(1'b1, 3'b011, 16'h0019, 4'h0, 16'hFFFF);
      check("R10 bad store strobes", {14'd0, c_we, c_re}, 16'd0);
      check("R10 bad store no rsp/fault", {14'd0, r_valid, r_fault}, 16'd0);
      issue(1'b1, 3'b100, 16'h0018, 4'h0, 16'hFFFF);
      check("R10 store code 100", {14'd0, c_we, c_io}, 16'd0);
      load_expect("R10 memory unchanged", 3'b001, 16'h0018, 4'h0, 16'h80F7);
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem_rdata = 16'h0000;
      rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_op = 3'b000;
      req_base = 16'h0000; req_disp = 4'h0; req_wdata = 16'h0000;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      t_stores();
      t_loads();
      t_misalign();
      t_io();
      t_illegal();
      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule